// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is a single channel of a reloading 8-bit down-counter. It is used in one of two ways. As a timer, it counts system clocks divided by a selectable prescale factor. As an event counter, it counts the active edges of an external clock/trigger pin. A register interface supplies a decoded control byte and a time-constant strobe. The channel returns the live count for bus reads, a one-cycle zero-count pulse, and an interrupt event pulse for a separate interrupt block.

Each time the count passes through zero, the channel reloads the stored constant and keeps counting with no idle cycle. In timer mode the channel can start on its own as soon as the constant is written, or it can wait for a trigger edge. Changing the active-edge polarity counts as one active edge. A soft reset parks the channel until a fresh constant arrives. A constant written while the channel runs is held back until the next reload.

Top module: `ctc_channel`

## Requirements
- R1: The 8-bit time constant N (code 0 means 256) is loaded when the channel starts and again at every zero count. With no gap between periods, consecutive zero-count pulses are exactly P*N system clocks apart in timer mode, where P is the prescale factor.
- R2: In timer mode (control bit 6 = 0) the count steps once per prescaler period. The period is 16 clocks when control bit 5 = 0 and 256 clocks when bit 5 = 1.
- R3: In counter mode (control bit 6 = 1) each active edge of `trg_pin` decrements the count by one. The pin passes through a two-flop synchronizer first.
- R4: Control bit 4 selects the active edge of `trg_pin`: 0 selects falling, 1 selects rising. Edges of the other direction leave the count unchanged.
- R5: A control write that changes bit 4 and has bit 1 clear acts as one active edge. In counter mode it decrements the count. It starts a timer that is waiting for its trigger. A write that leaves bit 4 unchanged has no such effect.
- R6: In timer mode with control bit 3 = 0, writing the constant to an idle channel starts the timer. With bit 3 = 1, the count holds at N until an active trigger edge arrives, and the prescaler starts counting from that edge.
- R7: A time constant written while the channel is waiting or counting leaves the current count untouched. It becomes the reload value at the next zero count.
- R8: A control write with bit 1 = 1 stops the channel at once, and the count holds. Only a following time-constant write restarts it.
- R9: `zc_o` is high for exactly one clock per zero count when N > 1. `irq_evt_o` pulses together with `zc_o` only when control bit 7 was 1.
- R10: Hardware reset (`rst_n` low) clears the count to 0, all control bits and the running state. Both `zc_o` and `irq_evt_o` are held low. Trigger edges then have no effect until the channel is programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| ctl_we | input | 1 | Strobe: load `ctl_wdata` as control byte |
| ctl_wdata | input | 8 | Control byte (b7 irq enable, b6 counter mode, b5 long prescale, b4 rising edge, b3 external trigger, b1 soft reset) |
| tc_we | input | 1 | Strobe: load `tc_wdata` as time constant |
| tc_wdata | input | 8 | Time constant, 0 encodes 256 |
| trg_pin | input | 1 | Asynchronous external clock/trigger |
| count_o | output | 8 | Current count (256 reads as 0) |
| zc_o | output | 1 | One-clock zero-count pulse |
| irq_evt_o | output | 1 | Zero-count interrupt event, gated by enable |

## Verification
Several properties are checked on every clock:
- the count is frozen while the channel is idle or waiting for its trigger;
- in timer mode the count moves only on a prescaler tick, and ticks never come back to back;
- a step that is not a reload lowers the count by exactly one;
- a reload brings in the constant that was stored before that clock;
- an interrupt event never occurs without a zero-count pulse.

Only the bench scenarios can show the following:
- the exact zero-to-zero spacing for each prescale factor and constant, including the 256 encoding;
- the count seen after a given number of pin edges of either polarity;
- the deferred use of a constant written mid-count;
- the start latency after a trigger edge or a polarity flip;
- the idle state after a soft or hardware reset.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  // Decoded control byte, MSB first so that the bit positions match the bus byte.
  typedef struct packed {
    logic irq_en;    // b7
    logic cnt_mode;  // b6: 1 = event counter, 0 = timer
    logic ps_long;   // b5: 1 = divide by long factor
    logic rise;      // b4: 1 = rising edge active
    logic ext_trig;  // b3: timer waits for trigger edge
    logic tc_next;   // b2: handled by bus decode
    logic srst;      // b1: soft reset
    logic ctl_id;    // b0: handled by bus decode
  } ctl_t;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_RUN  = 2'd2
  } ch_state_e;

endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int SHORT_LOG = 4,
  parameter int LONG_LOG  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_sel,
  output logic tick
);
  localparam logic [LONG_LOG-1:0] SHORT_LAST = LONG_LOG'((1 << SHORT_LOG) - 1);
  localparam logic [LONG_LOG-1:0] LONG_LAST  = '1;

  logic [LONG_LOG-1:0] pcnt_q;
  logic [LONG_LOG-1:0] last;

  assign last = long_sel ? LONG_LAST : SHORT_LAST;
  assign tick = run && (pcnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!run || tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R2: a prescaler period is never shorter than two clocks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ctc_trig_edge.sv
module ctc_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign edge_o = rise_sel ? (synced & ~prev_q) : (~synced & prev_q);

  // R3: two edges of one polarity are at least two clocks apart
  p_edge_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || (rise_sel != $past(rise_sel))));

endmodule

// File: rtl/ctc_downcounter.sv
module ctc_downcounter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic [CW-1:0] reload_val,
  output logic [CW:0]   cnt,
  output logic          zero_hit
);
  // A stored code of zero stands for the full range 2**CW.
  function automatic logic [CW:0] span(input logic [CW-1:0] v);
    logic [CW:0] r;
    r = {1'b0, v};
    if (v == '0) r = {1'b1, {CW{1'b0}}};
    return r;
  endfunction

  logic [CW:0] cnt_q;

  assign cnt      = cnt_q;
  assign zero_hit = dec && !load && (cnt_q == (CW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= span(load_val);
    end else if (zero_hit) begin
      cnt_q <= span(reload_val);
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1: the reload takes the constant that was stored before the zero
  p_reload_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (cnt_q == span($past(reload_val))));

  // R3: an ordinary step lowers the count by exactly one
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && (cnt_q > (CW+1)'(1))) |=> (cnt_q == $past(cnt_q) - (CW+1)'(1)));

endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SHORT_LOG   = 4,
  parameter int LONG_LOG    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          tc_we,
  input  logic [CW-1:0] tc_wdata,
  input  logic          trg_pin,
  output logic [CW-1:0] count_o,
  output logic          zc_o,
  output logic          irq_evt_o
);
  ctl_t          ctl_q;
  ctl_t          ctl_in;
  ch_state_e     st_q, st_d;
  logic [CW-1:0] tc_q;
  logic [CW:0]   cnt;
  logic          soft_rst, pol_flip, pin_edge, act_edge;
  logic          start, run_timer, pre_tick, dec, zero_hit;
  logic          zc_q, irq_q;
  logic          unused_bits;

  assign ctl_in = ctl_t'(ctl_wdata);

  // Named internal events
  assign soft_rst  = ctl_we && ctl_in.srst;
  assign pol_flip  = ctl_we && !ctl_in.srst && (ctl_in.rise != ctl_q.rise);
  assign act_edge  = pin_edge || pol_flip;
  assign start     = tc_we && (st_q == CH_IDLE) && !soft_rst;
  assign run_timer = (st_q == CH_RUN) && !ctl_q.cnt_mode;
  assign dec       = !soft_rst && (st_q == CH_RUN) &&
                     (ctl_q.cnt_mode ? act_edge : pre_tick);

  ctc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (trg_pin),
    .rise_sel (ctl_q.rise),
    .edge_o   (pin_edge)
  );

  ctc_prescaler #(.SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_timer),
    .long_sel (ctl_q.ps_long),
    .tick     (pre_tick)
  );

  ctc_downcounter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_val   (tc_wdata),
    .dec        (dec),
    .reload_val (tc_q),
    .cnt        (cnt),
    .zero_hit   (zero_hit)
  );

  always_comb begin
    st_d = st_q;
    if (soft_rst) begin
      st_d = CH_IDLE;
    end else if (start) begin
      st_d = (!ctl_q.cnt_mode && ctl_q.ext_trig) ? CH_WAIT : CH_RUN;
    end else if ((st_q == CH_WAIT) && act_edge) begin
      st_d = CH_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      ctl_q <= '0;
      tc_q  <= '0;
      zc_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      if (ctl_we) ctl_q <= ctl_in;
      if (tc_we)  tc_q  <= tc_wdata;
      zc_q  <= zero_hit;
      irq_q <= zero_hit && ctl_q.irq_en;
    end
  end

  assign count_o     = cnt[CW-1:0];
  assign zc_o        = zc_q;
  assign irq_evt_o   = irq_q;
  assign unused_bits = ^{ctl_q.tc_next, ctl_q.ctl_id, cnt[CW]};

  // R8: an idle channel keeps its count until a constant is written
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_IDLE) && !tc_we) |=> $stable(cnt));

  // R6: a timer that waits for its trigger does not count
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_WAIT) |=> $stable(cnt));

  // R2: a running timer moves only on a prescaler tick
  p_timer_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_timer && !pre_tick) |=> $stable(cnt));

  // R9: an interrupt event always comes with a zero-count pulse
  p_irq_with_zc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt_o |-> zc_o);

endmodule

// File: tb/ctc_channel_tb_top.sv
`timescale 1ns/1ps
module ctc_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       tc_we = 1'b0;
  logic [7:0] tc_wdata = 8'h00;
  logic       trg_pin = 1'b0;
  logic [7:0] count_o;
  logic       zc_o;
  logic       irq_evt_o;

  int checks = 0;
  int errors = 0;
  logic zc_seen = 1'b0;

  always #10 clk = ~clk;

  ctc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tc_we(tc_we), .tc_wdata(tc_wdata), .trg_pin(trg_pin),
    .count_o(count_o), .zc_o(zc_o), .irq_evt_o(irq_evt_o)
  );

  // Control byte bits
  localparam logic [7:0] B_IE = 8'h80, B_CNT = 8'h40, B_PS = 8'h20, B_RISE = 8'h10,
                         B_EXT = 8'h08, B_SR = 8'h02, B_ID = 8'h01;

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_in(input string tag, input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wcyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (zc_o) zc_seen = 1'b1;
    end
  endtask

  task automatic wctl(input logic [7:0] b);
    @(negedge clk); ctl_wdata = b; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wtc(input logic [7:0] b);
    @(negedge clk); tc_wdata = b; tc_we = 1'b1;
    @(negedge clk); tc_we = 1'b0;
  endtask

  task automatic pulse;
    trg_pin = 1'b1; wcyc(5);
    trg_pin = 1'b0; wcyc(5);
  endtask

  task automatic wait_zc(input int limit, output int n, output logic seen, output logic irq);
    seen = 1'b0; irq = 1'b0; n = 0;
    while (!seen && n < limit) begin
      @(negedge clk); n++;
      if (zc_o) begin seen = 1'b1; irq = irq_evt_o; end
    end
  endtask

  // Measures the spacing of two consecutive zero-count pulses.
  task automatic gap(input string tag, input int exp, input logic irq_exp);
    int n; logic s, i;
    wait_zc(exp * 3 + 100, n, s, i);
    chk_eq({tag, " first zero"}, s, 1);
    wait_zc(exp + 50, n, s, i);
    chk_eq({tag, " period"}, n, exp);
    chk_eq({tag, " R9 irq"}, i, irq_exp);
    @(negedge clk);
    if (exp > 1) chk_eq({tag, " R9 pulse width"}, zc_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n; logic s, i; logic [7:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_eq("R10 reset count", count_o, 0);
    chk_eq("R10 reset zc", zc_o, 0);
    chk_eq("R10 reset irq", irq_evt_o, 0);
    rst_n = 1'b1;
    wcyc(2);
    pulse(); pulse();
    chk_eq("R10 unprogrammed ignores pin", count_o, 0);

    // R1 R2 timer, short prescale, auto start, irq enabled
    wctl(B_IE | B_ID);
    wtc(8'd3);
    gap("R2 div16 N=3", 48, 1'b1);

    // R1 constant code 0 = 256, irq disabled
    wctl(B_SR | B_ID);
    wtc(8'd0);
    gap("R1 N=256", 4096, 1'b0);

    // R2 long prescale
    wctl(B_PS | B_SR | B_ID);
    wtc(8'd2);
    gap("R2 div256 N=2", 512, 1'b0);

    // R1 smallest constant
    wctl(B_SR | B_ID);
    wtc(8'd1);
    gap("R1 N=1", 16, 1'b0);

    // R8 soft reset stops and holds
    wtc(8'd0);
    wctl(B_SR | B_ID);
    wcyc(2);
    held = count_o;
    zc_seen = 1'b0;
    wcyc(600);
    chk_eq("R8 count held after soft reset", count_o, held);
    chk_eq("R8 no zero while stopped", zc_seen, 0);
    wtc(8'd4);
    gap("R8 restart N=4", 64, 1'b0);

    // R3 counter mode, rising edges
    wctl(B_CNT | B_RISE | B_SR | B_ID);
    wtc(8'd10);
    wcyc(2);
    chk_eq("R3 loaded", count_o, 10);
    for (int k = 0; k < 3; k++) pulse();
    chk_eq("R3 after 3 edges", count_o, 7);
    zc_seen = 1'b0;
    for (int k = 0; k < 6; k++) pulse();
    chk_eq("R3 after 9 edges", count_o, 1);
    chk_eq("R3 no early zero", zc_seen, 0);
    pulse();
    chk_eq("R1 counter reload", count_o, 10);
    chk_eq("R1 counter zero pulse", zc_seen, 1);

    // R7 constant written mid-count is deferred
    wtc(8'd4);
    wcyc(3);
    chk_eq("R7 count untouched by write", count_o, 10);
    zc_seen = 1'b0;
    for (int k = 0; k < 9; k++) pulse();
    chk_eq("R7 old count runs on", count_o, 1);
    pulse();
    chk_eq("R7 new constant used at reload", count_o, 4);
    chk_eq("R7 zero pulse", zc_seen, 1);

    // R4 falling polarity
    wctl(B_CNT | B_SR | B_ID);
    wtc(8'd6);
    trg_pin = 1'b1; wcyc(6);
    chk_eq("R4 rising edge ignored", count_o, 6);
    trg_pin = 1'b0; wcyc(6);
    chk_eq("R4 falling edge counted", count_o, 5);

    // R5 polarity flip acts as an edge
    wctl(B_CNT | B_RISE | B_ID);
    wcyc(2);
    chk_eq("R5 flip decrements", count_o, 4);
    wctl(B_CNT | B_RISE | B_ID);
    wcyc(2);
    chk_eq("R5 same polarity no effect", count_o, 4);
    wctl(B_CNT | B_ID);
    wcyc(2);
    chk_eq("R5 flip back decrements", count_o, 3);

    // R6 external trigger
    wctl(B_RISE | B_EXT | B_SR | B_ID);
    wtc(8'd2);
    zc_seen = 1'b0;
    wcyc(200);
    chk_eq("R6 waiting holds count", count_o, 2);
    chk_eq("R6 waiting no zero", zc_seen, 0);
    @(negedge clk); trg_pin = 1'b1;
    wait_zc(400, n, s, i);
    chk_in("R6 start after trigger edge", n, 32, 38);
    trg_pin = 1'b0;
    gap("R6 runs on after trigger", 32, 1'b0);

    // R5 polarity flip starts a waiting timer
    wctl(B_RISE | B_EXT | B_SR | B_ID);
    wtc(8'd2);
    wcyc(50);
    chk_eq("R5 waiting before flip", count_o, 2);
    wctl(B_EXT | B_ID);
    wait_zc(400, n, s, i);
    chk_in("R5 flip starts timer", n, 28, 38);

    // R10 hardware reset while running
    @(negedge clk); rst_n = 1'b0;
    wcyc(2);
    @(negedge clk); rst_n = 1'b1;
    zc_seen = 1'b0;
    s = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (zc_o) zc_seen = 1'b1;
      if (irq_evt_o) s = 1'b1;
    end
    chk_eq("R10 count cleared", count_o, 0);
    chk_eq("R10 zc held low", zc_seen, 0);
    chk_eq("R10 irq held low", s, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule